// File: doc/BRIEF.md
# Runtime Quality-Selectable Unsigned Multiplier with Isolated Column Islands

This block multiplies two unsigned operands in a fixed two-stage pipeline. The least significant half of the product columns is split into equal-width column groups ("islands"). A small quality controller turns a runtime quality level into an enable mask for these islands. An island that is switched off has its partial-product bits forced to zero at their inputs by AND gating, so its internal nodes stop toggling. Its product bits are then driven to a fixed bias pattern through output multiplexers.

The quality level is sampled with the operands and travels down the pipeline with them. Each operation therefore uses the level that was present when it was accepted. Latency is the same for every level and every data value, so the block can be placed in a larger pipeline as a drop-in multiplier. Level 0 gives the exact product. Each higher level removes one more group from the bottom, and the bias pattern keeps the mean error close to zero.

Top module: `qmul_iso`

## Requirements
- R1: While reset is asserted, and on the edge that releases it, `out_valid` is 0 and `product` is 0.
- R2: At quality level 0 every island is active, and `product` equals `a*b` exactly.
- R3: At quality level q (1 to 4), the partial-product bits a[i]&b[j] whose column i+j is below 4q contribute nothing. Product bits 4q and above equal the exact sum of the remaining partial-product bits.
- R4: Every isolated 4-bit group of `product` (group g covers bits 4g+3..4g) reads the constant 4'b1000, which is half the weight of that group's top column pair.
- R5: Level codes 5, 6 and 7 behave exactly like level 4.
- R6: An operand pair sampled with `in_valid`=1 on a rising edge shows its result, with `out_valid`=1, after the next rising edge. This holds for any data and any level. When `in_valid` was 0, `out_valid` is 0 at that point.
- R7: A level change applies only to operations sampled with or after the new level. Back-to-back operations with different levels each produce their own result.
- R8: The island enable mask is a thermometer code: isolated groups are always the lowest ones. A higher level never re-enables a group that a lower level isolates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and level are valid this cycle |
| a | input | 16 | Multiplicand, unsigned |
| b | input | 16 | Multiplier, unsigned |
| level | input | 3 | Quality level; 0 is exact, larger is coarser |
| out_valid | output | 1 | `product` holds a new result |
| product | output | 32 | Registered (approximate) product |

## Verification
The assertions assume that `a`, `b`, `level` and `in_valid` are known (non-X) on every rising edge after reset. They also assume the inputs are not released before two edges have passed since reset. This is because the latency and exact-result properties compare against input values two edges back. The bench drives all inputs to defined values from time zero and changes them only on falling edges. It holds reset over several edges and draws random operands and levels from a seeded generator, so every code 0 to 7 stays inside that contract.

// File: rtl/qmul_pkg.sv
package qmul_pkg;

  // Saturate a raw quality code to the number of islands available.
  function automatic int unsigned clamp_level(input int unsigned raw, input int unsigned n_isl);
    return (raw > n_isl) ? n_isl : raw;
  endfunction

  // Bias pattern for an isolated group: only the top bit of the group set.
  function automatic int unsigned bias_pattern(input int unsigned gw);
    return 32'd1 << (gw - 1);
  endfunction

endpackage

// File: rtl/qmul_qctl.sv
module qmul_qctl #(
  parameter int unsigned LW = 3,
  parameter int unsigned NG = 4
) (
  input  logic [LW-1:0] level,
  output logic [NG-1:0] isl_en
);
  import qmul_pkg::*;

  int unsigned eff;

  always_comb begin
    eff = clamp_level(32'(level), NG);
  end

  // Thermometer mask: groups at or above the effective level stay on.
  for (genvar g = 0; g < NG; g++) begin : g_mask
    assign isl_en[g] = (g >= eff);
  end
endmodule

// File: rtl/qmul_stage1.sv
module qmul_stage1 #(
  parameter int unsigned W  = 16,
  parameter int unsigned GW = 4,
  parameter int unsigned NG = 4,
  parameter int unsigned LW = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [W-1:0]    a,
  input  logic [W-1:0]    b,
  input  logic [LW-1:0]   level,
  input  logic [NG-1:0]   isl_en,
  output logic            s1_valid,
  output logic [LW-1:0]   s1_lvl,
  output logic [NG-1:0]   s1_en,
  output logic [2*W-1:0]  s1_even,
  output logic [2*W-1:0]  s1_odd
);
  localparam int unsigned PW = 2 * W;

  logic [PW-1:0] col_en;
  logic [PW-1:0] row [W];
  logic [PW-1:0] sum_even;
  logic [PW-1:0] sum_odd;

  // Column gating: columns inside an island follow its enable.
  for (genvar c = 0; c < PW; c++) begin : g_col
    if ((c / GW) < NG) begin : g_isl
      assign col_en[c] = isl_en[c / GW];
    end else begin : g_free
      assign col_en[c] = 1'b1;
    end
  end

  // Operand isolation: AND gating of every partial-product bit.
  for (genvar r = 0; r < W; r++) begin : g_row
    assign row[r] = ({{W{1'b0}}, a} << r) & col_en & {PW{b[r]}};
  end

  always_comb begin
    sum_even = '0;
    sum_odd  = '0;
    for (int r = 0; r < W; r++) begin
      if (r % 2 == 0) sum_even = sum_even + row[r];
      else            sum_odd  = sum_odd + row[r];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_lvl   <= '0;
      s1_en    <= '1;
      s1_even  <= '0;
      s1_odd   <= '0;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_lvl  <= level;
        s1_en   <= isl_en;
        s1_even <= sum_even;
        s1_odd  <= sum_odd;
      end
    end
  end
endmodule

// File: rtl/qmul_stage2.sv
module qmul_stage2 #(
  parameter int unsigned W  = 16,
  parameter int unsigned GW = 4,
  parameter int unsigned NG = 4,
  parameter int unsigned LW = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            s1_valid,
  input  logic [LW-1:0]   s1_lvl,
  input  logic [NG-1:0]   s1_en,
  input  logic [2*W-1:0]  s1_even,
  input  logic [2*W-1:0]  s1_odd,
  output logic            out_valid,
  output logic [LW-1:0]   out_lvl,
  output logic [2*W-1:0]  product
);
  import qmul_pkg::*;

  localparam int unsigned PW = 2 * W;
  localparam int unsigned IB = GW * NG;
  localparam logic [GW-1:0] BIAS = GW'(bias_pattern(GW));

  logic [PW-1:0] full_sum;
  logic [PW-1:0] muxed;

  assign full_sum = s1_even + s1_odd;

  // Output forcing multiplexers, one per island.
  for (genvar g = 0; g < NG; g++) begin : g_force
    assign muxed[g*GW +: GW] = s1_en[g] ? full_sum[g*GW +: GW] : BIAS;
  end
  if (PW > IB) begin : g_upper
    assign muxed[PW-1:IB] = full_sum[PW-1:IB];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_lvl   <= '0;
      product   <= '0;
    end else begin
      out_valid <= s1_valid;
      if (s1_valid) begin
        out_lvl <= s1_lvl;
        product <= muxed;
      end
    end
  end
endmodule

// File: rtl/qmul_iso.sv
module qmul_iso #(
  parameter int unsigned W  = 16,
  parameter int unsigned GW = 4,
  parameter int unsigned NG = 4,
  parameter int unsigned LW = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [W-1:0]    a,
  input  logic [W-1:0]    b,
  input  logic [LW-1:0]   level,
  output logic            out_valid,
  output logic [2*W-1:0]  product
);
  logic [NG-1:0]  isl_en;
  logic           s1_valid;
  logic [LW-1:0]  s1_lvl;
  logic [NG-1:0]  s1_en;
  logic [2*W-1:0] s1_even;
  logic [2*W-1:0] s1_odd;
  logic [LW-1:0]  out_lvl;

  qmul_qctl #(.LW(LW), .NG(NG)) u_qctl (
    .level  (level),
    .isl_en (isl_en)
  );

  qmul_stage1 #(.W(W), .GW(GW), .NG(NG), .LW(LW)) u_s1 (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .a        (a),
    .b        (b),
    .level    (level),
    .isl_en   (isl_en),
    .s1_valid (s1_valid),
    .s1_lvl   (s1_lvl),
    .s1_en    (s1_en),
    .s1_even  (s1_even),
    .s1_odd   (s1_odd)
  );

  qmul_stage2 #(.W(W), .GW(GW), .NG(NG), .LW(LW)) u_s2 (
    .clk       (clk),
    .rst       (rst),
    .s1_valid  (s1_valid),
    .s1_lvl    (s1_lvl),
    .s1_en     (s1_en),
    .s1_even   (s1_even),
    .s1_odd    (s1_odd),
    .out_valid (out_valid),
    .out_lvl   (out_lvl),
    .product   (product)
  );
endmodule

// File: rtl/qmul_iso_chk.sv
module qmul_iso_chk #(
  parameter int unsigned W  = 16,
  parameter int unsigned GW = 4,
  parameter int unsigned NG = 4,
  parameter int unsigned LW = 3
) (
  input logic            clk,
  input logic            rst,
  input logic            in_valid,
  input logic [W-1:0]    a,
  input logic [W-1:0]    b,
  input logic [LW-1:0]   level,
  input logic [NG-1:0]   isl_en,
  input logic [LW-1:0]   out_lvl,
  input logic            out_valid,
  input logic [2*W-1:0]  product
);
  logic [1:0] warm;
  logic [NG-1:0] off_mask;

  always_ff @(posedge clk) begin
    if (rst) warm <= '0;
    else if (warm != 2'd3) warm <= warm + 2'd1;
  end

  assign off_mask = ~isl_en;

  // R8
  mask_thermo_chk: assert property (@(posedge clk) disable iff (rst)
    (off_mask & (off_mask + 1'b1)) == '0);

  // R2
  exact_mode_chk: assert property (@(posedge clk) disable iff (rst)
    (warm >= 2'd2 && out_valid && out_lvl == '0) |->
      product == ((2*W)'($past(a, 2)) * (2*W)'($past(b, 2))));

  // R4
  low_bias_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_lvl != '0) |-> product[GW-1:0] == (GW'(1) << (GW-1)));

  // R6
  fixed_latency_chk: assert property (@(posedge clk) disable iff (rst)
    (warm >= 2'd2) |-> out_valid == $past(in_valid, 2));

  // R7
  level_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (warm >= 2'd2 && out_valid) |-> out_lvl == $past(level, 2));
endmodule

bind qmul_iso qmul_iso_chk #(.W(W), .GW(GW), .NG(NG), .LW(LW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .a         (a),
  .b         (b),
  .level     (level),
  .isl_en    (isl_en),
  .out_lvl   (out_lvl),
  .out_valid (out_valid),
  .product   (product)
);

// File: tb/test_qmul_iso.sv
module test_qmul_iso;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [15:0] a = '0;
  logic [15:0] b = '0;
  logic [2:0]  level = '0;
  logic        out_valid;
  logic [31:0] product;

  int total = 0;
  int bad = 0;

  logic        hv [2];
  logic [31:0] he [2];
  logic [2:0]  hl [2];

  always #10 clk = ~clk;

  qmul_iso i_qmul_iso (
    .clk(clk), .rst(rst), .in_valid(in_valid), .a(a), .b(b),
    .level(level), .out_valid(out_valid), .product(product)
  );

  function automatic logic [31:0] model(input logic [15:0] x, input logic [15:0] y,
                                        input logic [2:0] lv);
    int q;
    logic [63:0] s;
    q = (lv > 3'd4) ? 4 : int'(lv);
    s = '0;
    for (int i = 0; i < 16; i++)
      for (int j = 0; j < 16; j++)
        if ((i + j) >= 4 * q && x[i] && y[j]) s = s + (64'd1 << (i + j));
    for (int g = 0; g < q; g++) s = s + (64'd8 << (4 * g));
    return s[31:0];
  endfunction

  function automatic string tag(input logic [2:0] lv);
    if (lv == 3'd0) return "R2";
    if (lv > 3'd4) return "R5";
    return "R3/R4";
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One clock: compare outputs with the op driven two falling edges ago, then drive.
  task automatic step(input logic v, input logic [15:0] x, input logic [15:0] y,
                      input logic [2:0] lv);
    @(negedge clk);
    check(out_valid === hv[1], "R6 valid", {31'd0, out_valid}, {31'd0, hv[1]});
    if (hv[1]) check(product === he[1], tag(hl[1]), product, he[1]);
    hv[1] = hv[0]; he[1] = he[0]; hl[1] = hl[0];
    hv[0] = v; he[0] = model(x, y, lv); hl[0] = lv;
    in_valid = v; a = x; b = y; level = lv;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    seed = 32'd12345;
    void'($urandom(seed));
    hv[0] = 1'b0; hv[1] = 1'b0; he[0] = '0; he[1] = '0; hl[0] = '0; hl[1] = '0;
    repeat (4) @(negedge clk);
    // R1: reset state
    check(out_valid === 1'b0, "R1 valid", {31'd0, out_valid}, 32'd0);
    check(product === 32'd0, "R1 product", product, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check(out_valid === 1'b0 && product === 32'd0, "R1 release", product, 32'd0);

    // R2, R3, R4, R8: corner operands swept over every level
    for (int lv = 0; lv < 8; lv++) begin
      step(1'b1, 16'hFFFF, 16'hFFFF, 3'(lv));
      step(1'b1, 16'h0000, 16'hBEEF, 3'(lv));
      step(1'b1, 16'h0001, 16'h0001, 3'(lv));
      step(1'b1, 16'h8000, 16'h8000, 3'(lv));
    end
    // R6: lone op with idle gaps
    step(1'b0, 16'h0, 16'h0, 3'd0);
    step(1'b1, 16'h1234, 16'h5678, 3'd2);
    step(1'b0, 16'h0, 16'h0, 3'd0);
    step(1'b0, 16'h0, 16'h0, 3'd0);
    // R7: same operands, level changes every cycle
    for (int lv = 0; lv < 5; lv++) step(1'b1, 16'hA5A5, 16'h5A5A, 3'(4 - lv));
    // Random mix, all levels including saturating codes (R5)
    for (int k = 0; k < 2000; k++) begin
      step(($urandom % 4) != 0, 16'($urandom), 16'($urandom), 3'($urandom % 8));
    end
    step(1'b0, 16'h0, 16'h0, 3'd0);
    step(1'b0, 16'h0, 16'h0, 3'd0);
    step(1'b0, 16'h0, 16'h0, 3'd0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule